// File: doc/BRIEF.md
# Underflow-Triggered Down-Counting Timer Channel

This block is a single timer channel meant to sit beside others that share one prescaler. Each pulse on the tick input moves the count down by one while the channel is enabled. The channel fires when the count steps below zero, not when it reaches zero, so a start value of N gives an event after N+1 ticks. When it fires, the channel either reloads itself from a separate reload register and keeps going, or stops and parks the count at all-ones.

Software reaches the block through three write strobes that share one data bus: one for the live count, one for the reload value and one for the control word. All three values can be read back at all times. The control word holds enable, automatic restart, a one-shot load command, interrupt enable and a sticky pending flag that is cleared by writing one. The level interrupt output is the pending flag itself. Address decoding belongs to the surrounding bus logic.

Top module: `udt_channel`

## Requirements
- R1: After reset the count, the reload value and the control word all read 0, and irq is low.
- R2: A count write loads wdata into the count on the next clock. It takes priority over a load command and over a tick in the same cycle, and a tick in that cycle produces no event.
- R3: While control bit 0 (enable) is 1, each cycle with tick high lowers the count by one. When tick is low or enable is 0, the count stays where it is.
- R4: The event happens on a tick taken while the count is 0. A channel started at N therefore fires on tick N+1, and the count reads 0 just before that tick.
- R5: If control bit 1 (restart) is 1 at the event, the count is reloaded from the reload register and enable stays 1.
- R6: If restart is 0 at the event, the count becomes all-ones and enable is cleared, unless a control write in the same cycle sets enable again.
- R7: If control bit 3 (interrupt enable) is 1 at the event, control bit 4 (pending) becomes 1. If interrupt enable is 0, pending does not change.
- R8: Pending stays set until a control write with bit 4 at 1 clears it. A control write with bit 4 at 0 leaves it as it is. If an event and a clear fall in the same cycle, pending ends up set.
- R9: irq always equals control bit 4 as read back on ctl_q.
- R10: A control write with bit 2 (load) at 1 copies the reload value into the count. Bit 2 and bits 5 and above of ctl_q always read 0.
- R11: A reload write stores wdata, and rld_q returns it. This does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaler tick, one cycle wide |
| cnt_we | input | 1 | Write strobe for the count |
| rld_we | input | 1 | Write strobe for the reload value |
| ctl_we | input | 1 | Write strobe for the control word |
| wdata | input | W | Shared write data |
| cnt_q | output | W | Live count |
| rld_q | output | W | Reload value |
| ctl_q | output | 32 | Control word: bit 0 enable, 1 restart, 2 load (reads 0), 3 interrupt enable, 4 pending |
| irq | output | 1 | Level interrupt, equal to pending |

## Verification
The main sequence of loading a start value and ticking to expiry is run from a table. The table covers start values of 0, 1 and several larger values, and crosses restart on and off with interrupt enable on and off. Start value 0 checks the N+1 rule where it is easiest to get wrong. Crossing restart with interrupt enable checks that the reload-or-park choice and the pending flag are set independently. Directed cases then place competing actions in the same cycle: a count write against a tick, a count write against a load command, and an event against a pending clear. They also check that a write of 0 to pending leaves it set and that ticks have no effect while the channel is disabled.

// File: rtl/udt_pkg.sv
package udt_pkg;
  localparam int CTL_W = 32;
  localparam int B_EN  = 0;
  localparam int B_AR  = 1;
  localparam int B_LD  = 2;
  localparam int B_IE  = 3;
  localparam int B_IP  = 4;
  localparam int CTL_FIELD = B_IP + 1;

  typedef struct packed {
    logic en;
    logic ar;
    logic ie;
    logic ip;
  } udt_ctl_t;

  function automatic logic [CTL_W-1:0] ctl_to_word(udt_ctl_t c);
    logic [CTL_W-1:0] w;
    w       = '0;
    w[B_EN] = c.en;
    w[B_AR] = c.ar;
    w[B_IE] = c.ie;
    w[B_IP] = c.ip;
    return w;
  endfunction
endpackage

// File: rtl/udt_counter.sv
module udt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  input  logic         load_req,
  input  logic [W-1:0] rld_val,
  input  logic         step,
  input  logic         auto_rst,
  output logic [W-1:0] cnt_q,
  output logic         uf_evt
);
  localparam logic [W-1:0] ALL_ONES = '1;

  function automatic logic [W-1:0] next_down(logic [W-1:0] c);
    return c - {{(W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic is_floor(logic [W-1:0] c);
    return c == '0;
  endfunction

  logic wr_any;
  assign wr_any = cnt_we | load_req;
  assign uf_evt = step & is_floor(cnt_q) & ~wr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_we)     cnt_q <= cnt_wdata;
    else if (load_req)   cnt_q <= rld_val;
    else if (uf_evt)     cnt_q <= auto_rst ? rld_val : ALL_ONES;
    else if (step)       cnt_q <= next_down(cnt_q);
  end

  a_r2_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));
  a_r10_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && !cnt_we |=> cnt_q == $past(rld_val));
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt_q != '0 && !cnt_we && !load_req |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !cnt_we && !load_req |=> $stable(cnt_q));
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt && auto_rst |=> cnt_q == $past(rld_val));
  a_r6_park: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt && !auto_rst |=> &cnt_q);
endmodule

// File: rtl/udt_ctlreg.sv
module udt_ctlreg
  import udt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTL_FIELD-1:0] ctl_wdata,
  input  logic                 uf_evt,
  output udt_ctl_t             ctl,
  output logic                 load_req
);
  logic clr_req;
  assign load_req = ctl_we & ctl_wdata[B_LD];
  assign clr_req  = ctl_we & ctl_wdata[B_IP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      if (ctl_we) begin
        ctl.en <= ctl_wdata[B_EN];
        ctl.ar <= ctl_wdata[B_AR];
        ctl.ie <= ctl_wdata[B_IE];
      end else if (uf_evt && !ctl.ar) begin
        ctl.en <= 1'b0;
      end
      if (uf_evt && ctl.ie) ctl.ip <= 1'b1;
      else if (clr_req)     ctl.ip <= 1'b0;
    end
  end

  a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt && !ctl.ar && !ctl_we |=> !ctl.en);
  a_r7_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt && ctl.ie |=> ctl.ip);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !uf_evt |=> !ctl.ip);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.ip && !clr_req |=> ctl.ip);
endmodule

// File: rtl/udt_channel.sv
module udt_channel
  import udt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic             rld_we,
  input  logic             ctl_we,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     cnt_q,
  output logic [W-1:0]     rld_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             irq
);
  udt_ctl_t ctl;
  logic     load_req;
  logic     uf_evt;
  logic     step;

  assign step = tick & ctl.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rld_q <= '0;
    else if (rld_we) rld_q <= wdata;
  end

  udt_ctlreg u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(wdata[CTL_FIELD-1:0]),
    .uf_evt   (uf_evt),
    .ctl      (ctl),
    .load_req (load_req)
  );

  udt_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_we   (cnt_we),
    .cnt_wdata(wdata),
    .load_req (load_req),
    .rld_val  (rld_q),
    .step     (step),
    .auto_rst (ctl.ar),
    .cnt_q    (cnt_q),
    .uf_evt   (uf_evt)
  );

  assign ctl_q = ctl_to_word(ctl);
  assign irq   = ctl.ip;

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(uf_evt));
  a_r11_reload_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_we |=> $stable(rld_q));
endmodule

// File: tb/sim_udt_channel.sv
module sim_udt_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cnt_we = 1'b0, rld_we = 1'b0, ctl_we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] cnt_q, rld_q, ctl_q;
  logic        irq;
  int          n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  udt_channel #(.W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we), .rld_we(rld_we),
    .ctl_we(ctl_we), .wdata(wdata), .cnt_q(cnt_q), .rld_q(rld_q),
    .ctl_q(ctl_q), .irq(irq)
  );

  // {restart, irq enable, start value}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b1, 32'd0},
    {1'b1, 1'b1, 32'd1},
    {1'b0, 1'b0, 32'd3},
    {1'b1, 1'b0, 32'd4},
    {1'b1, 1'b1, 32'd7},
    {1'b0, 1'b1, 32'd2}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic t, logic cw, logic rw, logic kw, logic [31:0] d);
    @(negedge clk);
    tick = t; cnt_we = cw; rld_we = rw; ctl_we = kw; wdata = d;
    @(negedge clk);
    tick = 1'b0; cnt_we = 1'b0; rld_we = 1'b0; ctl_we = 1'b0; wdata = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #800000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", cnt_q, 0);
    chk("R1 reload", rld_q, 0);
    chk("R1 ctl", ctl_q, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;

    // R3: disabled channel ignores ticks
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'd9);
    ticks(3);
    chk("R3 disabled hold", cnt_q, 9);

    // R11: reload write does not touch the count
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 32'h1234_5678);
    chk("R11 reload readback", rld_q, 32'h1234_5678);
    chk("R11 count unchanged", cnt_q, 9);

    // table: load N, run to expiry
    foreach (VEC[k]) begin
      logic        ar, ie;
      logic [31:0] n, cw;
      {ar, ie, n} = VEC[k];
      cw = 32'h5 | (ar ? 32'h2 : 32'h0) | (ie ? 32'h8 : 32'h0);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, n);
      cyc(1'b0, 1'b0, 1'b0, 1'b1, cw);
      chk("R10 load copies reload", cnt_q, n);
      ticks(int'(n));
      chk("R4 zero before expiry", cnt_q, 0);
      chk("R4 no early pending", {31'd0, irq}, 0);
      ticks(1);
      chk("R5/R6 count after event", cnt_q, ar ? n : 32'hFFFF_FFFF);
      chk("R5/R6 enable after event", {31'd0, ctl_q[0]}, {31'd0, ar});
      chk("R7 pending", {31'd0, ctl_q[4]}, {31'd0, ie});
      chk("R9 irq tracks pending", {31'd0, irq}, {31'd0, ctl_q[4]});
      if (!ar) begin
        ticks(2);
        chk("R6 stopped count holds", cnt_q, 32'hFFFF_FFFF);
      end
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h10);
      chk("R8 write-one clears", {31'd0, irq}, 0);
    end

    // R3: enabled count steps down, idle cycles hold
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'd20);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h1);
    ticks(5);
    chk("R3 step down", cnt_q, 15);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
    chk("R3 idle hold", cnt_q, 15);

    // R2: count write beats tick
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 32'd40);
    chk("R2 write beats tick", cnt_q, 40);
    // R2: count write beats load (reload=100)
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 32'd100);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 32'h5);
    chk("R2 write beats load", cnt_q, 5);
    // R2: write at zero with tick causes no event
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h9);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 32'd0);
    chk("R2 no event on write", {31'd0, irq}, 0);

    // R8: write zero to pending leaves it; event beats clear
    ticks(1);
    chk("R7 pending after event", {31'd0, irq}, 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h8);
    chk("R8 write-zero keeps", {31'd0, irq}, 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h10);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 32'd0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h9);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 32'h19);
    chk("R8 event beats clear", {31'd0, irq}, 1);
    chk("R9 irq equals bit4", {31'd0, ctl_q[4]}, 1);

    // R10: readback masks load and upper bits
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFEF);
    chk("R10 ctl readback", ctl_q, 32'h1B);
    chk("R10 load via wide write", cnt_q, 100);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule